// File: doc/BRIEF.md
# Eight-bit ALU with nibble-carry flags

This block is the purely combinational arithmetic and logic unit of a small 8-bit processor core. It takes a working-register operand `w_opnd` and a second operand `f_opnd`, which is either a register-file byte or an instruction literal. It also takes an operation code and the stored carry bit. It returns the 8-bit result, a zero flag, a half (nibble) carry flag and a full carry flag. Three update strobes tell the status storage which of those flags the operation changes. The block does not store anything. Register reads, write-back and flag storage belong to the surrounding core.

Subtraction computes `f_opnd - w_opnd` by adding the two's complement of the working operand. Both carry flags therefore read as inverted borrows. The half carry is always the carry leaving bit 3. Rotates move through the carry bit in either direction. Nibble swap and the logical operations leave the carries untouched.

Top module: `alu8_dc`

## Requirements
- R1: With op code 0 (add), `{carry_out, result}` equals `w_opnd + f_opnd` as a 9-bit sum.
- R2: With op codes 0 and 1, `dcarry_out` is the carry leaving bit 3 of the addition performed. For add, that is the carry of `w_opnd[3:0] + f_opnd[3:0]`.
- R3: With op code 1 (subtract), `result` equals `f_opnd - w_opnd` modulo 256. `carry_out` is 1 exactly when `f_opnd >= w_opnd` (no borrow). `dcarry_out` is 1 exactly when `f_opnd[3:0] >= w_opnd[3:0]`.
- R4: `zero_out` is 1 exactly when `result` is 0, for every op code.
- R5: Op codes 0 and 1 assert `zero_upd`, `dcarry_upd` and `carry_upd` together.
- R6: The logical op codes give these results: 2 gives `w & f`, 3 gives `w | f`, 4 gives `w ^ f`, and 5 gives `~f`. Each asserts `zero_upd` only. On these codes `dcarry_out` and `carry_out` read 0.
- R7: Op code 6 (rotate right through carry) gives `result = {carry_in, f_opnd[7:1]}` and `carry_out = f_opnd[0]`. Only `carry_upd` is asserted.
- R8: Op code 7 (rotate left through carry) gives `result = {f_opnd[6:0], carry_in}` and `carry_out = f_opnd[7]`. Only `carry_upd` is asserted.
- R9: Op code 8 (swap) gives `result = {f_opnd[3:0], f_opnd[7:4]}`. No update strobe is asserted.
- R10: Op codes 9 to 15 pass `f_opnd` to `result` unchanged. No update strobe is asserted, and both carry outputs read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op | input | 4 | Operation code |
| w_opnd | input | 8 | Working-register operand |
| f_opnd | input | 8 | File or literal operand |
| carry_in | input | 1 | Current stored carry |
| result | output | 8 | Operation result |
| zero_out | output | 1 | Result-is-zero flag |
| dcarry_out | output | 1 | Carry out of bit 3 (inverted borrow on subtract) |
| carry_out | output | 1 | Carry out of bit 7, or the bit rotated out |
| zero_upd | output | 1 | Operation updates the zero flag |
| dcarry_upd | output | 1 | Operation updates the nibble carry |
| carry_upd | output | 1 | Operation updates the carry |

## Verification
The nibble carry and the full carry come from the same addition. The interesting cases are those where both fire at once, or where one fires without the other. An example is a low-nibble overflow that ripples through an all-ones upper nibble. The bench applies every operand pair for add and for subtract, so each combination of the two carries (and of the borrows on subtract) appears. It judges both against a model that sums the low nibbles and the full bytes separately. Rotates are mixed in with random carry-in, to show that the incoming carry lands in the vacated bit while the outgoing bit reaches `carry_out`.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

   typedef enum logic [3:0] {
      OP_ADD = 4'd0,
      OP_SUB = 4'd1,
      OP_AND = 4'd2,
      OP_IOR = 4'd3,
      OP_XOR = 4'd4,
      OP_COM = 4'd5,
      OP_RRC = 4'd6,
      OP_RLC = 4'd7,
      OP_SWP = 4'd8
   } alu_op_e;

   typedef struct packed {
      logic z;
      logic dc;
      logic c;
   } flag_set_t;

   localparam flag_set_t UPD_NONE  = '{z: 1'b0, dc: 1'b0, c: 1'b0};
   localparam flag_set_t UPD_ALL   = '{z: 1'b1, dc: 1'b1, c: 1'b1};
   localparam flag_set_t UPD_ZERO  = '{z: 1'b1, dc: 1'b0, c: 1'b0};
   localparam flag_set_t UPD_CARRY = '{z: 1'b0, dc: 1'b0, c: 1'b1};

endpackage

// File: rtl/alu8_nib_adder.sv
module alu8_nib_adder #(
   parameter int NIB_W = 4
) (
   input  logic [NIB_W-1:0] a,
   input  logic [NIB_W-1:0] b,
   input  logic             cin,
   output logic [NIB_W-1:0] sum,
   output logic             cout
);
   logic [NIB_W:0] wide;

   always_comb begin
      wide = {1'b0, a} + {1'b0, b} + {{NIB_W{1'b0}}, cin};
      sum  = wide[NIB_W-1:0];
      cout = wide[NIB_W];
   end
endmodule

// File: rtl/alu8_adder.sv
module alu8_adder #(
   parameter int WIDTH = 8,
   parameter int NIB_W = 4
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             cout,
   output logic             dcout
);
   localparam int NIBS = WIDTH / NIB_W;

   generate
      if (WIDTH % NIB_W != 0) begin : g_bad_split
         $error("alu8_adder: WIDTH must be a multiple of NIB_W");
      end
      if (NIBS < 2) begin : g_bad_count
         $error("alu8_adder: need at least two nibbles");
      end
   endgenerate

   logic [NIBS:0] chain;
   assign chain[0] = cin;

   for (genvar n = 0; n < NIBS; n++) begin : g_nib
      alu8_nib_adder #(.NIB_W(NIB_W)) u_nib (
         .a   (a[n*NIB_W +: NIB_W]),
         .b   (b[n*NIB_W +: NIB_W]),
         .cin (chain[n]),
         .sum (sum[n*NIB_W +: NIB_W]),
         .cout(chain[n+1])
      );
   end

   assign cout  = chain[NIBS];
   assign dcout = chain[1];
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
   parameter int WIDTH = 8
) (
   input  alu8_pkg::alu_op_e op,
   input  logic [WIDTH-1:0]  a,
   input  logic [WIDTH-1:0]  b,
   output logic [WIDTH-1:0]  y
);
   import alu8_pkg::*;

   always_comb begin
      unique case (op)
         OP_AND:  y = a & b;
         OP_IOR:  y = a | b;
         OP_XOR:  y = a ^ b;
         default: y = ~b;
      endcase
   end
endmodule

// File: rtl/alu8_rotate.sv
module alu8_rotate #(
   parameter int WIDTH = 8
) (
   input  logic             go_left,
   input  logic             cin,
   input  logic [WIDTH-1:0] f,
   output logic [WIDTH-1:0] y,
   output logic             cout
);
   always_comb begin
      if (go_left) begin
         y    = {f[WIDTH-2:0], cin};
         cout = f[WIDTH-1];
      end else begin
         y    = {cin, f[WIDTH-1:1]};
         cout = f[0];
      end
   end
endmodule

// File: rtl/alu8_dc.sv
module alu8_dc #(
   parameter int WIDTH = 8,
   parameter int NIB_W = 4
) (
   input  logic [3:0]       op,
   input  logic [WIDTH-1:0] w_opnd,
   input  logic [WIDTH-1:0] f_opnd,
   input  logic             carry_in,
   output logic [WIDTH-1:0] result,
   output logic             zero_out,
   output logic             dcarry_out,
   output logic             carry_out,
   output logic             zero_upd,
   output logic             dcarry_upd,
   output logic             carry_upd
);
   import alu8_pkg::*;

   localparam int HALF = WIDTH / 2;

   generate
      if (WIDTH < 4 || WIDTH % 2 != 0) begin : g_bad_width
         $error("alu8_dc: WIDTH must be even and at least 4");
      end
   endgenerate

   alu_op_e opc;
   assign opc = alu_op_e'(op);

   logic             is_sub;
   logic [WIDTH-1:0] add_b, add_sum, log_y, rot_y, swp_y;
   logic             add_c, add_dc, rot_c;
   flag_set_t        upd;

   assign is_sub = (opc == OP_SUB);
   assign add_b  = is_sub ? ~w_opnd : w_opnd;

   alu8_adder #(.WIDTH(WIDTH), .NIB_W(NIB_W)) u_add (
      .a    (f_opnd),
      .b    (add_b),
      .cin  (is_sub),
      .sum  (add_sum),
      .cout (add_c),
      .dcout(add_dc)
   );

   alu8_logic #(.WIDTH(WIDTH)) u_log (
      .op(opc),
      .a (w_opnd),
      .b (f_opnd),
      .y (log_y)
   );

   alu8_rotate #(.WIDTH(WIDTH)) u_rot (
      .go_left(opc == OP_RLC),
      .cin    (carry_in),
      .f      (f_opnd),
      .y      (rot_y),
      .cout   (rot_c)
   );

   assign swp_y = {f_opnd[HALF-1:0], f_opnd[WIDTH-1:HALF]};

   always_comb begin
      result     = f_opnd;
      upd        = UPD_NONE;
      carry_out  = 1'b0;
      dcarry_out = 1'b0;
      case (opc)
         OP_ADD, OP_SUB: begin
            result     = add_sum;
            upd        = UPD_ALL;
            carry_out  = add_c;
            dcarry_out = add_dc;
         end
         OP_AND, OP_IOR, OP_XOR, OP_COM: begin
            result = log_y;
            upd    = UPD_ZERO;
         end
         OP_RRC, OP_RLC: begin
            result    = rot_y;
            upd       = UPD_CARRY;
            carry_out = rot_c;
         end
         OP_SWP: result = swp_y;
         default: ;
      endcase
   end

   assign zero_out   = ~|result;
   assign zero_upd   = upd.z;
   assign dcarry_upd = upd.dc;
   assign carry_upd  = upd.c;
endmodule

// File: rtl/alu8_dc_chk.sv
module alu8_dc_chk #(
   parameter int WIDTH = 8
) (
   input logic [3:0]       op,
   input logic [WIDTH-1:0] w_opnd,
   input logic [WIDTH-1:0] f_opnd,
   input logic             carry_in,
   input logic [WIDTH-1:0] result,
   input logic             carry_out,
   input logic             dcarry_out,
   input logic             zero_upd,
   input logic             dcarry_upd,
   input logic             carry_upd
);
   always_comb begin
      if (op == 4'd0)
         assert_add_sum_R1: assert ({carry_out, result} == {1'b0, w_opnd} + {1'b0, f_opnd});
      if (op == 4'd1)
         assert_sub_borrow_R3: assert (carry_out == (f_opnd >= w_opnd));
      if (op <= 4'd1)
         assert_arith_upd_R5: assert (zero_upd && dcarry_upd && carry_upd);
      if (op >= 4'd2 && op <= 4'd5)
         assert_logic_upd_R6: assert (zero_upd && !dcarry_upd && !carry_upd && !carry_out);
      if (op == 4'd6)
         assert_rrc_R7: assert (carry_out == f_opnd[0] && result[WIDTH-1] == carry_in && carry_upd && !zero_upd);
      if (op == 4'd7)
         assert_rlc_R8: assert (carry_out == f_opnd[WIDTH-1] && result[0] == carry_in && carry_upd && !dcarry_upd);
      if (op == 4'd8)
         assert_swap_R9: assert (result == {f_opnd[WIDTH/2-1:0], f_opnd[WIDTH-1:WIDTH/2]} && !zero_upd && !carry_upd);
      if (op >= 4'd9)
         assert_pass_R10: assert (result == f_opnd && !zero_upd && !dcarry_upd && !carry_upd && !dcarry_out);
   end
endmodule

bind alu8_dc alu8_dc_chk #(.WIDTH(WIDTH)) u_chk (
   .op        (op),
   .w_opnd    (w_opnd),
   .f_opnd    (f_opnd),
   .carry_in  (carry_in),
   .result    (result),
   .carry_out (carry_out),
   .dcarry_out(dcarry_out),
   .zero_upd  (zero_upd),
   .dcarry_upd(dcarry_upd),
   .carry_upd (carry_upd)
);

// File: tb/alu8_dc_tb.sv
`timescale 1ns/1ps
module alu8_dc_tb;
   logic       clk = 1'b0;
   logic [3:0] op = '0;
   logic [7:0] w_opnd = '0, f_opnd = '0;
   logic       carry_in = 1'b0;
   logic [7:0] result;
   logic       zero_out, dcarry_out, carry_out, zero_upd, dcarry_upd, carry_upd;
   int         n_chk = 0, n_bad = 0;
   bit         done = 0;

   always #5 clk = ~clk;

   alu8_dc u_dut (
      .op(op), .w_opnd(w_opnd), .f_opnd(f_opnd), .carry_in(carry_in),
      .result(result), .zero_out(zero_out), .dcarry_out(dcarry_out),
      .carry_out(carry_out), .zero_upd(zero_upd), .dcarry_upd(dcarry_upd),
      .carry_upd(carry_upd)
   );

   // model packing: {res[7:0], z, dc, c, zu, dcu, cu}
   function automatic logic [13:0] model(input logic [3:0] o, input logic [7:0] w,
                                         input logic [7:0] f, input logic ci);
      logic [7:0] r; logic dc, c, zu, du, cu;
      logic [4:0] lo; logic [8:0] full;
      r = f; dc = 0; c = 0; zu = 0; du = 0; cu = 0;
      case (o)
         4'd0: begin // R1 R2
            lo = {1'b0, f[3:0]} + {1'b0, w[3:0]};
            full = {1'b0, f} + {1'b0, w};
            r = full[7:0]; c = full[8]; dc = lo[4]; zu = 1; du = 1; cu = 1;
         end
         4'd1: begin // R3
            r = f - w; c = (f >= w); dc = (f[3:0] >= w[3:0]); zu = 1; du = 1; cu = 1;
         end
         4'd2: begin r = w & f; zu = 1; end // R6
         4'd3: begin r = w | f; zu = 1; end
         4'd4: begin r = w ^ f; zu = 1; end
         4'd5: begin r = ~f;    zu = 1; end
         4'd6: begin r = {ci, f[7:1]}; c = f[0]; cu = 1; end // R7
         4'd7: begin r = {f[6:0], ci}; c = f[7]; cu = 1; end // R8
         4'd8: r = {f[3:0], f[7:4]};                         // R9
         default: ;                                          // R10
      endcase
      return {r, (r == 8'd0), dc, c, zu, du, cu};
   endfunction

   function automatic string req_of(input logic [3:0] o);
      case (o)
         4'd0: return "R1/R2/R4/R5";
         4'd1: return "R3/R2/R4/R5";
         4'd2, 4'd3, 4'd4, 4'd5: return "R6/R4";
         4'd6: return "R7";
         4'd7: return "R8";
         4'd8: return "R9";
         default: return "R10";
      endcase
   endfunction

   task automatic apply(input logic [3:0] o, input logic [7:0] w,
                        input logic [7:0] f, input logic ci);
      logic [13:0] exp, act;
      @(negedge clk);
      op = o; w_opnd = w; f_opnd = f; carry_in = ci;
      #2;
      exp = model(o, w, f, ci);
      act = {result, zero_out, dcarry_out, carry_out, zero_upd, dcarry_upd, carry_upd};
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s op=%0d w=%h f=%h ci=%b actual=%h expected=%h",
                  req_of(o), o, w, f, ci, act, exp);
      end
   endtask

   initial begin
      int seed;
      seed = 32'h5EED_0A1B;
      void'($urandom(seed));
      // zero operands: R4 zero flag on add
      apply(4'd0, 8'h00, 8'h00, 1'b0);
      // directed corners: R2 nibble ripple, R3 equal operands, R7/R8 carry-in
      apply(4'd0, 8'h01, 8'hFF, 1'b0);
      apply(4'd0, 8'h08, 8'h08, 1'b0);
      apply(4'd1, 8'h5A, 8'h5A, 1'b1);
      apply(4'd1, 8'h01, 8'h10, 1'b0);
      apply(4'd6, 8'h00, 8'h01, 1'b1);
      apply(4'd7, 8'h00, 8'h80, 1'b0);
      apply(4'd5, 8'h00, 8'hFF, 1'b1);
      apply(4'd8, 8'h00, 8'hA5, 1'b0);
      apply(4'd15, 8'h33, 8'h00, 1'b1);
      // exhaustive add and subtract: R1 R2 R3 R5
      for (int a = 0; a < 256; a++)
         for (int b = 0; b < 256; b++) begin
            apply(4'd0, a[7:0], b[7:0], b[0]);
            apply(4'd1, a[7:0], b[7:0], a[0]);
         end
      // random mix over all op codes: R4 R6 R7 R8 R9 R10
      for (int i = 0; i < 3000; i++)
         apply(4'($urandom()), 8'($urandom()), 8'($urandom()), 1'($urandom()));
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #3_000_000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule